// File: doc/BRIEF.md
# Sub-Dword Operand Select and Merge

This stage sits around the arithmetic unit of a 32-bit lane datapath. On the way in, each of two source operands can be cut down to one byte or one halfword. The field is then widened back to 32 bits, either with zeros or by copying its top bit. Floating-point magnitude and sign controls act on bit 31 after that widening. On the way out, the low bits of the arithmetic result are placed into one byte or halfword of the destination. The remaining destination bits are then cleared, filled from the sign of the field, or kept from the old destination value.

Inputs are taken when `inValid` is high. All outputs are registered and appear one clock later, with `outValid` high. The arithmetic operation itself is outside this block. A typical use is to condition operands in one cycle and merge a result computed elsewhere in the same cycle.

Select codes (shared by both sources and by the destination): 0 = whole word, 1 = byte bits 7:0, 2 = byte bits 15:8, 3 = byte bits 23:16, 4 = byte bits 31:24, 5 = halfword bits 15:0, 6 = halfword bits 31:16, 7 = treated as whole word. Destination policy codes: 0 = keep old bits, 1 = zero fill, 2 = sign fill, 3 = treated as keep old bits.

Top module: `subdword_sel_merge`

## Requirements
- R1: While reset (`rstN` low) is asserted and after it is released, `outValid` is 0 and `opnd0`, `opnd1` and `dstMerged` are all zero until the first accepted input.
- R2: Every cycle with `inValid` high yields exactly one cycle of `outValid` high on the next clock edge, carrying that input's results; a cycle with `inValid` low yields `outValid` low on the next edge. Inputs can be accepted back to back.
- R3: A source select code picks the field: 0 and 7 whole word, 1 to 4 bytes at bits 7:0, 15:8, 23:16, 31:24, 5 bits 15:0, 6 bits 31:16. Without sign extension the field is zero-extended to 32 bits.
- R4: With a source's sign-extend flag set, bits above a byte or halfword field are copied from the field's top bit. With the whole word selected the flag changes nothing.
- R5: With a source's integer flag clear, the abs flag clears bit 31 of the extended value and the neg flag then inverts bit 31. With both flags set, bit 31 is 1.
- R6: With a source's integer flag set, its abs and neg flags have no effect on the conditioned operand.
- R7: The destination select code (same encoding as R3) names the field written. The result's low bits (width of the field) land in that field.
- R8: Policy 1 (zero fill) makes every destination bit outside the field 0.
- R9: Policy 2 (sign fill) copies the field's top bit into all bits above the field and zeroes all bits below it.
- R10: Policy 0, and policy 3 likewise, keeps every destination bit outside the field equal to the old destination value.
- R11: With the whole-word destination selected, the merged destination equals the result under every policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Inputs are taken this cycle |
| src0 | input | 32 | First source operand |
| src1 | input | 32 | Second source operand |
| oldDst | input | 32 | Current destination value |
| result | input | 32 | Operation result to merge |
| src0Sel | input | 3 | Field select for src0 |
| src1Sel | input | 3 | Field select for src1 |
| src0Sext | input | 1 | Sign-extend src0 field |
| src1Sext | input | 1 | Sign-extend src1 field |
| src0Abs | input | 1 | Clear sign of src0 (floating point) |
| src1Abs | input | 1 | Clear sign of src1 (floating point) |
| src0Neg | input | 1 | Invert sign of src0 (floating point) |
| src1Neg | input | 1 | Invert sign of src1 (floating point) |
| src0IsInt | input | 1 | src0 is an integer; abs and neg ignored |
| src1IsInt | input | 1 | src1 is an integer; abs and neg ignored |
| dstSel | input | 3 | Destination field select |
| dstPolicy | input | 2 | Treatment of destination bits outside the field |
| outValid | output | 1 | Outputs carry the previous cycle's input |
| opnd0 | output | 32 | Conditioned first operand |
| opnd1 | output | 32 | Conditioned second operand |
| dstMerged | output | 32 | Merged destination value |

## Verification
The hardest case is the interplay of sign extension with the floating-point sign controls. Abs and neg must act on bit 31 only after a narrow field has been widened, so the field's top bit must be 1 for the order to be visible. The stimulus therefore picks byte and halfword fields with the top bit set and asserts sign extension and abs together. It also drives the integer flag with abs and neg both raised. On the destination side, sign fill and keep-old are each applied to a middle byte. This is the only field position that has bits both above and below it, so both halves of each policy are observed.

// File: rtl/sdsm_pkg.sv
package sdsm_pkg;

  localparam int DATA_W     = 32;
  localparam int BYTE_W     = 8;
  localparam int HALF_W     = 2 * BYTE_W;
  localparam int LANES      = DATA_W / BYTE_W;
  localparam int LANE_IDX_W = $clog2(LANES);
  localparam int SHIFT_W    = $clog2(DATA_W);
  localparam int SEL_W      = 3;
  localparam int POL_W      = 2;
  localparam int N_SRC      = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_WHOLE = 3'd0,
    SEL_B0    = 3'd1,
    SEL_B1    = 3'd2,
    SEL_B2    = 3'd3,
    SEL_B3    = 3'd4,
    SEL_H0    = 3'd5,
    SEL_H1    = 3'd6,
    SEL_RSVD  = 3'd7
  } selCode_t;

  typedef enum logic [POL_W-1:0] {
    POL_KEEP  = 2'd0,
    POL_ZERO  = 2'd1,
    POL_SIGN  = 2'd2,
    POL_KEEP2 = 2'd3
  } policy_t;

  // Decoded field: neither flag set means whole word
  typedef struct packed {
    logic                  isByte;
    logic                  isHalf;
    logic [LANE_IDX_W-1:0] lane;
  } fieldDec_t;

  typedef struct packed {
    logic                   capture;
    fieldDec_t [N_SRC-1:0]  srcField;
    logic [N_SRC-1:0]       srcSext;
    logic [N_SRC-1:0]       fpAbs;
    logic [N_SRC-1:0]       fpNeg;
    fieldDec_t              dstField;
    logic                   padZero;
    logic                   signFill;
    logic                   keepOld;
  } strobe_t;

  function automatic fieldDec_t decodeSel(input logic [SEL_W-1:0] code);
    fieldDec_t f;
    f = '0;
    case (code)
      SEL_B0:  begin f.isByte = 1'b1; f.lane = LANE_IDX_W'(0); end
      SEL_B1:  begin f.isByte = 1'b1; f.lane = LANE_IDX_W'(1); end
      SEL_B2:  begin f.isByte = 1'b1; f.lane = LANE_IDX_W'(2); end
      SEL_B3:  begin f.isByte = 1'b1; f.lane = LANE_IDX_W'(3); end
      SEL_H0:  begin f.isHalf = 1'b1; f.lane = LANE_IDX_W'(0); end
      SEL_H1:  begin f.isHalf = 1'b1; f.lane = LANE_IDX_W'(2); end
      default: f = '0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/sdsm_ctrl.sv
module sdsm_ctrl
  import sdsm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [N_SRC*SEL_W-1:0]  srcSelBus,
  input  logic [N_SRC-1:0]        srcSext,
  input  logic [N_SRC-1:0]        srcAbs,
  input  logic [N_SRC-1:0]        srcNeg,
  input  logic [N_SRC-1:0]        srcIsInt,
  input  logic [SEL_W-1:0]        dstSel,
  input  logic [POL_W-1:0]        dstPolicy,
  output strobe_t                 strb,
  output logic                    outValid
);

  always_comb begin
    strb          = '0;
    strb.capture  = inValid;
    for (int i = 0; i < N_SRC; i++) begin
      strb.srcField[i] = decodeSel(srcSelBus[i*SEL_W +: SEL_W]);
      strb.srcSext[i]  = srcSext[i];
      strb.fpAbs[i]    = srcAbs[i] & ~srcIsInt[i];
      strb.fpNeg[i]    = srcNeg[i] & ~srcIsInt[i];
    end
    strb.dstField = decodeSel(dstSel);
    strb.padZero  = (dstPolicy == POL_ZERO);
    strb.signFill = (dstPolicy == POL_SIGN);
    strb.keepOld  = (dstPolicy == POL_KEEP) || (dstPolicy == POL_KEEP2);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R7
  dst_field_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.dstField.isByte, strb.dstField.isHalf}));

endmodule

// File: rtl/sdsm_datapath.sv
module sdsm_datapath
  import sdsm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [N_SRC*DATA_W-1:0] srcBus,
  input  logic [DATA_W-1:0]       oldDst,
  input  logic [DATA_W-1:0]       result,
  output logic [N_SRC*DATA_W-1:0] opndBus,
  output logic [DATA_W-1:0]       dstMerged
);

  function automatic logic [DATA_W-1:0] fieldMask(input fieldDec_t f);
    if (f.isByte)      return DATA_W'({BYTE_W{1'b1}});
    else if (f.isHalf) return DATA_W'({HALF_W{1'b1}});
    else               return {DATA_W{1'b1}};
  endfunction

  function automatic logic [SHIFT_W-1:0] fieldShift(input fieldDec_t f);
    return SHIFT_W'(f.lane) * SHIFT_W'(BYTE_W);
  endfunction

  function automatic logic fieldTop(input fieldDec_t f, input logic [DATA_W-1:0] v);
    if (f.isByte)      return v[BYTE_W-1];
    else if (f.isHalf) return v[HALF_W-1];
    else               return v[DATA_W-1];
  endfunction

  // ---------------- source conditioning ----------------
  logic [DATA_W-1:0] opndNext [N_SRC];
  logic [DATA_W-1:0] opndQ    [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : gSrc
    logic [DATA_W-1:0] srcVal;
    logic [DATA_W-1:0] rawField;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] extVal;
    logic              narrow;
    logic              signBit;

    assign srcVal = srcBus[g*DATA_W +: DATA_W];

    always_comb begin
      mask     = fieldMask(strb.srcField[g]);
      narrow   = strb.srcField[g].isByte | strb.srcField[g].isHalf;
      rawField = (srcVal >> fieldShift(strb.srcField[g])) & mask;
      extVal   = rawField;
      if (narrow && strb.srcSext[g] && fieldTop(strb.srcField[g], rawField))
        extVal = rawField | ~mask;
      signBit = extVal[DATA_W-1];
      if (strb.fpAbs[g]) signBit = 1'b0;
      if (strb.fpNeg[g]) signBit = ~signBit;
      opndNext[g] = {signBit, extVal[DATA_W-2:0]};
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            opndQ[g] <= '0;
      else if (strb.capture) opndQ[g] <= opndNext[g];
    end

    assign opndBus[g*DATA_W +: DATA_W] = opndQ[g];

    // R5
    abs_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.capture && strb.fpAbs[g] && !strb.fpNeg[g] |=> !opndQ[g][DATA_W-1]);

    // R5
    abs_then_neg_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.capture && strb.fpAbs[g] && strb.fpNeg[g] |=> opndQ[g][DATA_W-1]);

    // R3
    whole_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.capture && !strb.srcField[g].isByte && !strb.srcField[g].isHalf
      && !strb.fpAbs[g] && !strb.fpNeg[g]
      |=> opndQ[g] == $past(srcBus[g*DATA_W +: DATA_W]));
  end

  // ---------------- destination merge ----------------
  logic [DATA_W-1:0] dMask;
  logic [SHIFT_W-1:0] dShift;
  logic [DATA_W-1:0] resLow;
  logic [DATA_W-1:0] placed;
  logic [DATA_W-1:0] fieldPos;
  logic [DATA_W-1:0] belowMask;
  logic [DATA_W-1:0] aboveMask;
  logic [DATA_W-1:0] outside;
  logic [DATA_W-1:0] mergeNext;
  logic              resTop;

  always_comb begin
    dMask     = fieldMask(strb.dstField);
    dShift    = fieldShift(strb.dstField);
    resLow    = result & dMask;
    resTop    = fieldTop(strb.dstField, resLow);
    placed    = resLow << dShift;
    fieldPos  = dMask << dShift;
    belowMask = ~({DATA_W{1'b1}} << dShift);
    aboveMask = ~(fieldPos | belowMask);
    if (strb.keepOld)       outside = oldDst & ~fieldPos;
    else if (strb.signFill) outside = resTop ? aboveMask : '0;
    else                    outside = '0;
    mergeNext = placed | outside;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dstMerged <= '0;
    else if (strb.capture) dstMerged <= mergeNext;
  end

  // R11
  whole_dst_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && !strb.dstField.isByte && !strb.dstField.isHalf
    |=> dstMerged == $past(result));

  // R10
  keep_low_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && strb.keepOld && strb.dstField.isByte && strb.dstField.lane == '0
    |=> dstMerged[DATA_W-1:BYTE_W] == $past(oldDst[DATA_W-1:BYTE_W]));

  // R8
  pad_upper_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && strb.padZero && strb.dstField.isHalf && strb.dstField.lane != '0
    |=> dstMerged[HALF_W-1:0] == '0);

endmodule

// File: rtl/subdword_sel_merge.sv
module subdword_sel_merge
  import sdsm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] src0,
  input  logic [31:0] src1,
  input  logic [31:0] oldDst,
  input  logic [31:0] result,
  input  logic [2:0]  src0Sel,
  input  logic [2:0]  src1Sel,
  input  logic        src0Sext,
  input  logic        src1Sext,
  input  logic        src0Abs,
  input  logic        src1Abs,
  input  logic        src0Neg,
  input  logic        src1Neg,
  input  logic        src0IsInt,
  input  logic        src1IsInt,
  input  logic [2:0]  dstSel,
  input  logic [1:0]  dstPolicy,
  output logic        outValid,
  output logic [31:0] opnd0,
  output logic [31:0] opnd1,
  output logic [31:0] dstMerged
);

  strobe_t                 strb;
  logic [N_SRC*DATA_W-1:0] opndBus;

  sdsm_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .srcSelBus ({src1Sel, src0Sel}),
    .srcSext   ({src1Sext, src0Sext}),
    .srcAbs    ({src1Abs, src0Abs}),
    .srcNeg    ({src1Neg, src0Neg}),
    .srcIsInt  ({src1IsInt, src0IsInt}),
    .dstSel    (dstSel),
    .dstPolicy (dstPolicy),
    .strb      (strb),
    .outValid  (outValid)
  );

  sdsm_datapath i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .srcBus    ({src1, src0}),
    .oldDst    (oldDst),
    .result    (result),
    .opndBus   (opndBus),
    .dstMerged (dstMerged)
  );

  assign opnd0 = opndBus[DATA_W-1:0];
  assign opnd1 = opndBus[2*DATA_W-1:DATA_W];

endmodule

// File: tb/test_subdword_sel_merge.sv
module test_subdword_sel_merge;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] src0 = '0, src1 = '0, oldDst = '0, result = '0;
  logic [2:0]  src0Sel = '0, src1Sel = '0, dstSel = '0;
  logic        src0Sext = 0, src1Sext = 0, src0Abs = 0, src1Abs = 0;
  logic        src0Neg = 0, src1Neg = 0, src0IsInt = 1, src1IsInt = 1;
  logic [1:0]  dstPolicy = '0;
  logic        outValid;
  logic [31:0] opnd0, opnd1, dstMerged;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] s0, s1, old, res;
    logic [2:0]  sel0, sel1, dsel;
    logic        sx0, sx1, ab0, ab1, ng0, ng1, in0, in1;
    logic [1:0]  pol;
  } stim_t;

  typedef struct {
    logic [31:0] e0, e1, ed;
    string       tag;
  } exp_t;

  exp_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  subdword_sel_merge i_subdword_sel_merge (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .src0(src0), .src1(src1), .oldDst(oldDst), .result(result),
    .src0Sel(src0Sel), .src1Sel(src1Sel),
    .src0Sext(src0Sext), .src1Sext(src1Sext),
    .src0Abs(src0Abs), .src1Abs(src1Abs),
    .src0Neg(src0Neg), .src1Neg(src1Neg),
    .src0IsInt(src0IsInt), .src1IsInt(src1IsInt),
    .dstSel(dstSel), .dstPolicy(dstPolicy),
    .outValid(outValid), .opnd0(opnd0), .opnd1(opnd1), .dstMerged(dstMerged)
  );

  // field position and width from the select code
  function automatic void fieldOf(input logic [2:0] code, output int lo, output int w);
    case (code)
      3'd1: begin lo = 0;  w = 8;  end
      3'd2: begin lo = 8;  w = 8;  end
      3'd3: begin lo = 16; w = 8;  end
      3'd4: begin lo = 24; w = 8;  end
      3'd5: begin lo = 0;  w = 16; end
      3'd6: begin lo = 16; w = 16; end
      default: begin lo = 0; w = 32; end
    endcase
  endfunction

  function automatic logic [31:0] modelSrc(input logic [31:0] s, input logic [2:0] code,
                                           input logic sx, input logic ab, input logic ng,
                                           input logic isInt);
    int lo, w;
    logic [31:0] v;
    logic top;
    fieldOf(code, lo, w);
    top = s[lo + w - 1];
    for (int b = 0; b < 32; b++)
      v[b] = (b < w) ? s[lo + b] : (sx ? top : 1'b0);
    if (!isInt) begin
      if (ab) v[31] = 1'b0;
      if (ng) v[31] = ~v[31];
    end
    return v;
  endfunction

  function automatic logic [31:0] modelDst(input logic [31:0] res, input logic [31:0] old,
                                           input logic [2:0] code, input logic [1:0] pol);
    int lo, w;
    logic [31:0] v;
    logic top;
    fieldOf(code, lo, w);
    top = res[w - 1];
    for (int b = 0; b < 32; b++) begin
      if (b >= lo && b < lo + w)   v[b] = res[b - lo];
      else if (pol == 2'd1)        v[b] = 1'b0;
      else if (pol == 2'd2)        v[b] = (b >= lo + w) ? top : 1'b0;
      else                         v[b] = old[b];
    end
    return v;
  endfunction

  function automatic stim_t blank();
    stim_t s;
    s.s0 = '0; s.s1 = '0; s.old = '0; s.res = '0;
    s.sel0 = 3'd0; s.sel1 = 3'd0; s.dsel = 3'd0;
    s.sx0 = 0; s.sx1 = 0; s.ab0 = 0; s.ab1 = 0; s.ng0 = 0; s.ng1 = 0;
    s.in0 = 1; s.in1 = 1; s.pol = 2'd0;
    return s;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: apply one item and push its expectation
  task automatic drive(input stim_t s, input string tag);
    exp_t e;
    @(negedge clk);
    src0 = s.s0; src1 = s.s1; oldDst = s.old; result = s.res;
    src0Sel = s.sel0; src1Sel = s.sel1; dstSel = s.dsel; dstPolicy = s.pol;
    src0Sext = s.sx0; src1Sext = s.sx1; src0Abs = s.ab0; src1Abs = s.ab1;
    src0Neg = s.ng0; src1Neg = s.ng1; src0IsInt = s.in0; src1IsInt = s.in1;
    inValid = 1'b1;
    e.e0  = modelSrc(s.s0, s.sel0, s.sx0, s.ab0, s.ng0, s.in0);
    e.e1  = modelSrc(s.s1, s.sel1, s.sx1, s.ab1, s.ng1, s.in1);
    e.ed  = modelDst(s.res, s.old, s.dsel, s.pol);
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // monitor: pop and compare at the falling edge after each registered output
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sbq.size() == 0) begin
        check("R2", "unexpected outValid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(e.tag, "opnd0", opnd0, e.e0);
        check(e.tag, "opnd1", opnd1, e.e1);
        check(e.tag, "dstMerged", dstMerged, e.ed);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    errors++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    stim_t s;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", "outValid in reset", {31'd0, outValid}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1 after release
    check("R1", "outValid after reset", {31'd0, outValid}, 32'd0);
    check("R1", "opnd0 after reset", opnd0, 32'd0);
    check("R1", "dstMerged after reset", dstMerged, 32'd0);

    // R3 byte and halfword picks, reserved code
    s = blank(); s.s0 = 32'hA1B2C3D4; s.sel0 = 3'd3; s.s1 = 32'hA1B2C3D4; s.sel1 = 3'd6;
    drive(s, "R3");
    s = blank(); s.s0 = 32'h89ABCDEF; s.sel0 = 3'd7; s.s1 = 32'h89ABCDEF; s.sel1 = 3'd4;
    drive(s, "R3");
    idle(1);

    // R4 sign extension of narrow field, no effect on whole word
    s = blank(); s.s0 = 32'h00008000; s.sel0 = 3'd2; s.sx0 = 1;
    s.s1 = 32'h80000000; s.sel1 = 3'd0; s.sx1 = 1;
    drive(s, "R4");
    s = blank(); s.s0 = 32'h9234_0000; s.sel0 = 3'd6; s.sx0 = 1;
    s.s1 = 32'h0000_0070; s.sel1 = 3'd1; s.sx1 = 1;
    drive(s, "R4");

    // R5 abs, neg, abs before neg, abs after sign extension
    s = blank(); s.in0 = 0; s.in1 = 0;
    s.s0 = 32'h80000001; s.ab0 = 1; s.s1 = 32'h00000001; s.ng1 = 1;
    drive(s, "R5");
    s = blank(); s.in0 = 0; s.in1 = 0;
    s.s0 = 32'h00000005; s.ab0 = 1; s.ng0 = 1;
    s.s1 = 32'h00000080; s.sel1 = 3'd1; s.sx1 = 1; s.ab1 = 1;
    drive(s, "R5");

    // R6 integer flag ignores abs and neg
    s = blank(); s.s0 = 32'h80000000; s.ab0 = 1; s.ng0 = 1;
    s.s1 = 32'h0000FF00; s.sel1 = 3'd2; s.sx1 = 1; s.ng1 = 1;
    drive(s, "R6");
    idle(2);

    // R7 and R8 zero fill around a middle byte and the upper half
    s = blank(); s.res = 32'h123456AB; s.old = 32'hFFFFFFFF; s.dsel = 3'd2; s.pol = 2'd1;
    drive(s, "R8");
    s = blank(); s.res = 32'hFFFF8001; s.old = 32'hFFFFFFFF; s.dsel = 3'd6; s.pol = 2'd1;
    drive(s, "R7");

    // R9 sign fill, negative and positive field
    s = blank(); s.res = 32'h000000AB; s.old = 32'hFFFFFFFF; s.dsel = 3'd2; s.pol = 2'd2;
    drive(s, "R9");
    s = blank(); s.res = 32'hFFFF1234; s.old = 32'hFFFFFFFF; s.dsel = 3'd5; s.pol = 2'd2;
    drive(s, "R9");
    s = blank(); s.res = 32'h00000080; s.old = 32'h0; s.dsel = 3'd3; s.pol = 2'd2;
    drive(s, "R9");

    // R10 keep old bits, codes 0 and 3
    s = blank(); s.res = 32'h000000EE; s.old = 32'h11223344; s.dsel = 3'd3; s.pol = 2'd0;
    drive(s, "R10");
    s = blank(); s.res = 32'h0000BEEF; s.old = 32'h11223344; s.dsel = 3'd6; s.pol = 2'd3;
    drive(s, "R10");

    // R11 whole destination under each policy
    for (int p = 0; p < 4; p++) begin
      s = blank(); s.res = 32'h8765FEDC; s.old = 32'h0F0F0F0F; s.dsel = 3'd0; s.pol = 2'(p);
      drive(s, "R11");
    end
    idle(1);

    // R2 back-to-back random items
    for (int n = 0; n < 200; n++) begin
      s.s0 = $urandom; s.s1 = $urandom; s.old = $urandom; s.res = $urandom;
      s.sel0 = 3'($urandom); s.sel1 = 3'($urandom); s.dsel = 3'($urandom);
      s.pol = 2'($urandom);
      s.sx0 = 1'($urandom); s.sx1 = 1'($urandom); s.ab0 = 1'($urandom); s.ab1 = 1'($urandom);
      s.ng0 = 1'($urandom); s.ng1 = 1'($urandom); s.in0 = 1'($urandom); s.in1 = 1'($urandom);
      drive(s, "R2");
      if (($urandom % 5) == 0) idle(1);
    end
    idle(4);

    // R2 nothing left pending
    check("R2", "pending items", sbq.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule